// File: doc/BRIEF.md
# Segment Lookaside Buffer Unit

This block is a small, fully associative table of address segments. Each entry maps the upper bits of an effective address (the segment ID) to a virtual segment ID. On a hit, the block forms the virtual page number that a later hashed page walk would consume. Software-style commands drive all updates:

- a two-operand entry load;
- a legacy 4-bit segment-register load, which the block recodes into an ordinary entry load;
- invalidation of the one entry that covers an address;
- a table-wide flush that never removes entry 0.

The lookup port is purely combinational. A miss on an enabled lookup raises a segment fault, which the surrounding pipeline turns into an exception. A read-back port returns the two stored operand words of any entry, so that a trap handler can rebuild the table state.

Top module: `seg_lookaside_unit`

## Requirements
- R1: An entry matches only if its valid flag is set. When the entry's segment-size flag is clear, its stored segment ID is compared with EA[63:28]. When the flag is set, the compare uses EA[63:40].
- R2: On a hit, `lk_vpn` is (EA masked to its segment offset) >> 12, ORed with the entry VSID << (segment shift − 12). The segment shift is 28 for a small segment and 40 for a large one.
- R3: A load takes its index from ESID-operand bits [11:0], and an index at or above ENTRIES is ignored. The ESID-operand fields are the segment ID at [63:28] and the valid flag at [27]. The VSID-operand fields are:
  - segment size at [62];
  - VSID at [61:12] for a 256 MB segment or [61:24] for a 1 TB segment;
  - supervisor key at [11], problem key at [10] and no-execute at [9];
  - large page at [8], class at [7] and page-size selector at [5:4].
- R4: `lk_pgsz` is encoded 0=4K, 1=64K, 2=16M. It is fixed at load time:
  - 4K when the large-page flag is clear;
  - otherwise 16M, except that selector 01 with `mps_en` high gives 64K.
- R5: A flush clears the valid flag and both stored words of entries 1 to ENTRIES−1, and leaves entry 0 unchanged.
- R6: A legacy load performs an entry load with the following operands:
  - ESID operand = num<<28 with the valid flag set, so the index is 0;
  - VSID operand = val[27:0]<<12 | val[30:28]<<9.
- R7: An address invalidate clears the valid flag of the lowest-index entry that the address hits. A miss changes nothing.
- R8: When several entries match, the lowest index is reported.
- R9: Updates take effect at the clock edge. A lookup in the same cycle sees the old contents.
- R10: `rd_esid`/`rd_vsid` return the stored ESID word (segment ID bits plus the valid flag) and the stored VSID word of entry `rd_idx`. For an index at or above ENTRIES they return zero.
- R11: `seg_fault` is high exactly when `lk_en` is high and the lookup misses.
- R12: When several commands arrive in the same cycle, only one is performed, in this priority: entry load, then legacy load, then flush, then address invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the table |
| mps_en | input | 1 | Enables the multiple page-size decode |
| wr_en | input | 1 | Entry load command |
| wr_vsid_op | input | 64 | VSID operand word |
| wr_esid_op | input | 64 | ESID operand word |
| sr_en | input | 1 | Legacy segment-register load |
| sr_num | input | 4 | Segment register number |
| sr_val | input | 32 | Segment register value |
| inv_en | input | 1 | Invalidate the entry covering `inv_ea` |
| inv_ea | input | 64 | Address to invalidate |
| inv_all | input | 1 | Flush entries 1 to ENTRIES−1 |
| lk_en | input | 1 | Lookup is live (qualifies the fault) |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the winning entry |
| lk_vsid | output | 50 | VSID of the winning entry |
| lk_vpn | output | VPN_W | Virtual page number |
| lk_pgsz | output | 2 | Base page-size class |
| lk_ks | output | 1 | Supervisor key |
| lk_kp | output | 1 | Problem key |
| lk_nx | output | 1 | No-execute |
| lk_class | output | 1 | Class bit |
| seg_fault | output | 1 | Enabled lookup missed |
| rd_idx | input | 12 | Read-back index |
| rd_esid | output | 64 | Stored ESID word |
| rd_vsid | output | 64 | Stored VSID word |

## Verification
A corrupted valid flag or segment ID shows up in the same cycle on `lk_hit`, `lk_idx` and `seg_fault` for any address in the affected segment. A corrupted VSID or page-size class appears at once on `lk_vpn` and `lk_pgsz`. The bench sweeps several offsets in every entry, so a wrong segment-size mask or a wrong shift changes the number it compares. A bad command decode (flush sparing, index range, legacy recoding) is visible one edge after the command, both through lookups and through the read-back words.

// File: rtl/seg_lookaside_unit.sv
module seg_lookaside_unit #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int VPN_W   = 66
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mps_en,
  input  logic               wr_en,
  input  logic [63:0]        wr_vsid_op,
  input  logic [63:0]        wr_esid_op,
  input  logic               sr_en,
  input  logic [3:0]         sr_num,
  input  logic [31:0]        sr_val,
  input  logic               inv_en,
  input  logic [63:0]        inv_ea,
  input  logic               inv_all,
  input  logic               lk_en,
  input  logic [63:0]        lk_ea,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [49:0]        lk_vsid,
  output logic [VPN_W-1:0]   lk_vpn,
  output logic [1:0]         lk_pgsz,
  output logic               lk_ks,
  output logic               lk_kp,
  output logic               lk_nx,
  output logic               lk_class,
  output logic               seg_fault,
  input  logic [11:0]        rd_idx,
  output logic [63:0]        rd_esid,
  output logic [63:0]        rd_vsid
);
  localparam logic [63:0] ESID_KEEP = {36'hFFFFFFFFF, 1'b1, 27'd0};

  logic [ENTRIES-1:0] valid;
  logic [63:0]        e_word [ENTRIES];
  logic [63:0]        v_word [ENTRIES];
  logic [1:0]         pgsz   [ENTRIES];

  function automatic logic seg_match(input logic [63:0] ew, input logic [63:0] vw,
                                     input logic [63:0] ea);
    return vw[62] ? (ew[63:40] == ea[63:40]) : (ew[63:28] == ea[63:28]);
  endfunction

  // lowest matching index wins for both lookup and invalidate
  logic [IDX_W-1:0] inv_idx;
  logic             inv_hit;
  always_comb begin
    lk_hit = 1'b0; lk_idx = '0; inv_hit = 1'b0; inv_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid[i] && seg_match(e_word[i], v_word[i], lk_ea)) begin
        lk_hit = 1'b1; lk_idx = IDX_W'(i);
      end
      if (valid[i] && seg_match(e_word[i], v_word[i], inv_ea)) begin
        inv_hit = 1'b1; inv_idx = IDX_W'(i);
      end
    end
  end

  logic [63:0]      sel_v;
  logic [VPN_W-1:0] big_part, small_part;
  assign sel_v      = v_word[lk_idx];
  assign lk_vsid    = sel_v[62] ? {12'd0, sel_v[61:24]} : sel_v[61:12];
  assign big_part   = (VPN_W'(lk_vsid) << 28) | VPN_W'(lk_ea[39:12]);
  assign small_part = (VPN_W'(lk_vsid) << 16) | VPN_W'(lk_ea[27:12]);
  assign lk_vpn     = lk_hit ? (sel_v[62] ? big_part : small_part) : '0;
  assign lk_pgsz    = lk_hit ? pgsz[lk_idx] : 2'd0;
  assign lk_ks      = lk_hit & sel_v[11];
  assign lk_kp      = lk_hit & sel_v[10];
  assign lk_nx      = lk_hit & sel_v[9];
  assign lk_class   = lk_hit & sel_v[7];
  assign seg_fault  = lk_en & ~lk_hit;

  logic             rd_ok;
  logic [IDX_W-1:0] rd_sel;
  assign rd_ok   = 32'(rd_idx) < ENTRIES;
  assign rd_sel  = IDX_W'(rd_idx);
  assign rd_esid = rd_ok ? e_word[rd_sel] : 64'd0;
  assign rd_vsid = rd_ok ? v_word[rd_sel] : 64'd0;

  // legacy segment-register load is recoded into an ordinary load
  logic [63:0]      w_rs, w_rb;
  logic             w_go, w_ok;
  logic [IDX_W-1:0] w_idx;
  logic [1:0]       w_pg;
  assign w_go  = wr_en | sr_en;
  assign w_rs  = wr_en ? wr_vsid_op
                       : ((64'(sr_val[27:0]) << 12) | (64'(sr_val[30:28]) << 9));
  assign w_rb  = wr_en ? wr_esid_op : ((64'(sr_num) << 28) | (64'd1 << 27));
  assign w_ok  = 32'(w_rb[11:0]) < ENTRIES;
  assign w_idx = IDX_W'(w_rb[11:0]);
  assign w_pg  = !w_rs[8] ? 2'd0 : (mps_en && w_rs[5:4] == 2'b01) ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_word[i] <= '0; v_word[i] <= '0; pgsz[i] <= '0;
      end
    end else if (w_go) begin
      if (w_ok) begin
        valid[w_idx]  <= w_rb[27];
        e_word[w_idx] <= w_rb & ESID_KEEP;
        v_word[w_idx] <= w_rs;
        pgsz[w_idx]   <= w_pg;
      end
    end else if (inv_all) begin
      for (int i = 1; i < ENTRIES; i++) begin
        valid[i] <= 1'b0; e_word[i] <= '0; v_word[i] <= '0;
      end
    end else if (inv_en && inv_hit) begin
      valid[inv_idx] <= 1'b0;
    end
  end

  p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid[lk_idx]);
  p_fault_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && valid == '0) |-> seg_fault);
  p_bad_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_ok) |=> $stable(valid));
  p_spare_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_go && inv_all) |=> (valid[ENTRIES-1:1] == '0) && (valid[0] == $past(valid[0]))
                          && (e_word[0] == $past(e_word[0])));
  p_legacy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sr_en) |=> valid[0] && (e_word[0][31:28] == $past(sr_num)));
  p_inv_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_go && !inv_all && inv_en && inv_hit) |=> !valid[$past(inv_idx)]);
endmodule

// File: tb/seg_lookaside_unit_test.sv
module seg_lookaside_unit_test;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic mps_en = 0, wr_en = 0, sr_en = 0, inv_en = 0, inv_all = 0, lk_en = 0;
  logic [63:0] wr_vsid_op = 0, wr_esid_op = 0, inv_ea = 0, lk_ea = 0;
  logic [3:0]  sr_num = 0;
  logic [31:0] sr_val = 0;
  logic [11:0] rd_idx = 0;
  logic lk_hit, lk_ks, lk_kp, lk_nx, lk_class, seg_fault;
  logic [2:0]  lk_idx;
  logic [49:0] lk_vsid;
  logic [65:0] lk_vpn;
  logic [1:0]  lk_pgsz;
  logic [63:0] rd_esid, rd_vsid;

  seg_lookaside_unit #(.ENTRIES(N)) uut (.*);

  int vectors = 0, misses = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [79:0] got, input logic [79:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] mk_rs(bit big, logic [49:0] vs, bit ks, bit kp, bit nx,
                                        bit lg, logic [1:0] lp, bit cls);
    return (64'(big) << 62) | (64'(vs) << (big ? 24 : 12)) | (64'(ks) << 11) |
           (64'(kp) << 10) | (64'(nx) << 9) | (64'(lg) << 8) | (64'(cls) << 7) |
           (64'(lp) << 4);
  endfunction

  function automatic logic [63:0] mk_rb(bit big, logic [35:0] sid, bit v, int idx);
    return (64'(sid) << (big ? 40 : 28)) | (64'(v) << 27) | 64'(idx);
  endfunction

  task automatic load(input logic [63:0] rs, input logic [63:0] rb);
    @(negedge clk); wr_en = 1; wr_vsid_op = rs; wr_esid_op = rb;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic look(input logic [63:0] ea);
    lk_ea = ea; lk_en = 1; #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset: everything misses, read-back zero
    look(64'h1000_0000);
    chk("R11 reset hit", lk_hit, 0);
    chk("R11 reset fault", seg_fault, 1);
    rd_idx = 3; #1;
    chk("R10 reset rd", rd_esid, 0);

    // R1 R2 R3: small segments in every entry, several offsets
    for (int i = 0; i < N; i++)
      load(mk_rs(0, 50'h100 + 50'(i), i[0], i[1], i[2], 0, 0, i[0]), mk_rb(0, 36'(i + 1), 1, i));
    @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++) begin
        logic [63:0] ea;
        ea = (64'(i + 1) << 28) | (64'(k) * 64'h3F5_1234);
        look(ea);
        chk("R1 hit", lk_hit, 1);
        chk("R8 idx", lk_idx, 80'(i));
        chk("R2 vpn", lk_vpn, (80'(50'h100 + 50'(i)) << 16) | 80'(ea[27:12]));
        chk("R3 keys", {lk_ks, lk_kp, lk_nx, lk_class}, {i[0], i[1], i[2], i[0]});
        chk("R11 no fault", seg_fault, 0);
      end
    lk_en = 0; #1;
    chk("R11 idle fault", seg_fault, 0);

    // R1 R2: large segment in entry 7
    load(mk_rs(1, 50'h2A_BCDE, 0, 0, 0, 0, 0, 0), mk_rb(1, 36'd5, 1, 7));
    @(negedge clk);
    look((64'd5 << 40) | 64'h12_3456_789A);
    chk("R1 1T hit", lk_hit, 1);
    chk("R1 1T idx", lk_idx, 7);
    chk("R2 1T vpn", lk_vpn, (80'h2A_BCDE << 28) | 80'(40'h12_3456_789A >> 12));
    chk("R2 1T vsid", lk_vsid, 80'h2A_BCDE);
    look(64'd8 << 28);
    chk("R1 old seg gone", lk_hit, 0);

    // R8: duplicate segment in entry 6, entry 2 wins
    load(mk_rs(0, 50'h777, 0, 0, 0, 0, 0, 0), mk_rb(0, 36'd3, 1, 6));
    @(negedge clk);
    look(64'd3 << 28);
    chk("R8 lowest wins", lk_idx, 2);
    chk("R8 vsid", lk_vsid, 80'h102);

    // R3: out-of-range index ignored
    load(mk_rs(0, 50'h999, 0, 0, 0, 0, 0, 0), mk_rb(0, 36'h77, 1, 9));
    @(negedge clk);
    look(64'h77 << 28);
    chk("R3 oob ignored", lk_hit, 0);
    look(64'd4 << 28);
    chk("R3 others intact", lk_vsid, 80'h103);

    // R4: page size decode on entry 3
    for (int m = 0; m < 2; m++)
      for (int lg = 0; lg < 2; lg++)
        for (int lp = 0; lp < 4; lp++) begin
          logic [1:0] exp_pg;
          mps_en = m[0];
          load(mk_rs(0, 50'h103, 0, 0, 0, lg[0], 2'(lp), 0), mk_rb(0, 36'd4, 1, 3));
          exp_pg = (lg == 0) ? 2'd0 : (m == 1 && lp == 1) ? 2'd1 : 2'd2;
          look(64'd4 << 28);
          chk("R4 pgsz", lk_pgsz, 80'(exp_pg));
        end
    mps_en = 0;

    // R9: same-cycle load and lookup sees old contents
    @(negedge clk);
    wr_en = 1; wr_vsid_op = mk_rs(0, 50'h55, 0, 0, 0, 0, 0, 0); wr_esid_op = mk_rb(0, 36'h55, 1, 4);
    look(64'h55 << 28);
    chk("R9 before edge", lk_hit, 0);
    @(negedge clk); wr_en = 0; #1;
    chk("R9 after edge", lk_hit, 1);
    chk("R9 idx", lk_idx, 4);

    // R12: load beats flush in the same cycle
    @(negedge clk);
    wr_en = 1; inv_all = 1;
    wr_vsid_op = mk_rs(0, 50'h66, 0, 0, 0, 0, 0, 0); wr_esid_op = mk_rb(0, 36'h66, 1, 5);
    @(negedge clk); wr_en = 0; inv_all = 0;
    look(64'd3 << 28);
    chk("R12 flush suppressed", lk_hit, 1);
    look(64'h66 << 28);
    chk("R12 load done", lk_idx, 5);

    // R7: invalidate by address
    @(negedge clk); inv_en = 1; inv_ea = (64'd2 << 28) | 64'h123;
    @(negedge clk); inv_en = 0;
    look(64'd2 << 28);
    chk("R7 cleared", lk_hit, 0);
    look(64'd1 << 28);
    chk("R7 neighbour kept", lk_hit, 1);
    @(negedge clk); inv_en = 1; inv_ea = 64'hABC << 28;
    @(negedge clk); inv_en = 0;
    look(64'd1 << 28);
    chk("R7 miss no effect", lk_hit, 1);

    // R5: flush spares entry 0
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    look(64'd1 << 28);
    chk("R5 entry0 hit", lk_idx, 0);
    chk("R5 entry0 hit flag", lk_hit, 1);
    look(64'd3 << 28);
    chk("R5 others gone", lk_hit, 0);
    rd_idx = 5; #1;
    chk("R5 rd cleared", {rd_esid, rd_vsid}, 0);
    rd_idx = 0; #1;
    chk("R10 rd esid", rd_esid, (64'd1 << 28) | (64'd1 << 27));
    chk("R10 rd vsid", rd_vsid, mk_rs(0, 50'h100, 0, 0, 0, 0, 0, 0));

    // R6: legacy segment-register load
    @(negedge clk); sr_en = 1; sr_num = 4'hA; sr_val = 32'h5123_4567;
    @(negedge clk); sr_en = 0;
    rd_idx = 0; #1;
    chk("R6 esid word", rd_esid, (64'hA << 28) | (64'd1 << 27));
    chk("R6 vsid word", rd_vsid, (64'h123_4567 << 12) | (64'd5 << 9));
    look(64'hA << 28);
    chk("R6 hit", lk_hit, 1);
    chk("R6 vsid", lk_vsid, 80'h123_4567);
    chk("R6 keys", {lk_ks, lk_kp, lk_nx}, 3'b101);
    chk("R6 pgsz", lk_pgsz, 0);

    // R10: out-of-range read-back
    rd_idx = 12'd9; #1;
    chk("R10 oob rd", {rd_esid, rd_vsid}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule